// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor that finishes every instruction between two consecutive rising clock edges. It supports nine operations. Five are register-to-register arithmetic and logic operations. Two move a word between the register file and data memory. Two change the flow of control: a conditional branch when two registers are equal, and an absolute jump. The core holds the program counter, a 32-entry register file with two combinational read ports and one clocked write port, an ALU, sign extension, the branch and jump target logic, and the operand and write-back selectors.

Instruction storage and data storage are two separate word arrays inside the core. Before it runs a program, the surrounding logic fills them through a load port, usually while reset is held. Three groups of outputs show what the core does in each cycle:

- the program counter;
- the register write-back (enable, register number, value);
- the data-memory store (enable, byte address, value).

An integrating block or a bench can follow execution through these outputs without looking inside the core.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. During reset `wb_en` and `dm_we` stay low, so neither the registers nor data memory change.
- R2: An instruction that is neither a taken branch nor a jump advances the program counter by 4, through an adder that is separate from the ALU. The following words act as no-ops that only advance the program counter:
  - any opcode (bits 31:26) other than 0x00, 0x23, 0x2B, 0x04 or 0x02;
  - opcode 0x00 with a function code other than those listed in R3 and R4.
- R3: Opcode 0x00 selects a register-to-register operation. Its fields are source A in bits 25:21, source B in bits 20:16, destination in bits 15:11 and function code in bits 5:0. Function codes 0x20, 0x22, 0x24 and 0x25 write A+B, A−B, A AND B and A OR B to the destination. The result shows on `wb_reg`/`wb_data` with `wb_en` high.
- R4: Function code 0x2A writes 1 when A is less than B as signed two's-complement values, and 0 otherwise.
- R5: Register 0 always reads as zero. An instruction whose destination is register 0 changes nothing and keeps `wb_en` low.
- R6: Opcode 0x23 loads into the register in bits 20:16 the data word at address R[bits 25:21] plus the sign-extended 16-bit offset in bits 15:0.
- R7: Opcode 0x2B stores R[bits 20:16] at the same kind of address. In that cycle `dm_we` is high, with the address on `dm_addr` and the value on `dm_wdata`, and no register is written.
- R8: Opcode 0x04 compares R[bits 25:21] with R[bits 20:16].
  - If they are equal, the next program counter is PC+4 plus the sign-extended offset shifted left by 2. This works for forward and backward offsets.
  - If they differ, the next program counter is PC+4.
- R9: Opcode 0x02 sets the next program counter to {(PC+4)[31:28], bits 25:0, 2'b00}.
- R10: With `ld_en` high, `ld_data` is written at a rising edge into the array that `ld_sel` picks (0 = instruction, 1 = data). The word index is taken from `ld_addr` above bit 1.
- R11: A register write takes effect only at the clock edge. An instruction that reads its own destination register sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load-port write enable |
| ld_sel | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr | input | 32 | Load byte address |
| ld_data | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | Register write this cycle (nonzero destination) |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |
| dm_we | output | 1 | Data store this cycle |
| dm_addr | output | 32 | Data access byte address (ALU result) |
| dm_wdata | output | 32 | Store value |

## Verification
Every ALU operation is swept over all ordered pairs of eight operands, including zero, ±1, the largest positive value and the most negative value. A comparison done unsigned, or a swapped subtraction, therefore gives a wrong result on the very first pair where the sign matters. Stores and loads use both positive and negative offsets, so a zero-extended immediate sends data to the wrong word. Branches are taken forward, not taken, and taken backward inside a counted loop. If a branch target were not shifted or not sign-extended, the program counter would leave the expected sequence, and a wrong backward target would make the loop never end. The bench also checks writes aimed at register 0, a destination that is read in the same instruction, and undecoded words. Each of these would expose, in turn, a writable register 0, a register file that writes through to its read ports, and a decoder that lets unknown words write state.

// File: rtl/sc_cpu.sv
module sc_cpu #(
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic        ld_sel,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] pc_o,
  output logic        wb_en,
  output logic [4:0]  wb_reg,
  output logic [31:0] wb_data,
  output logic        dm_we,
  output logic [31:0] dm_addr,
  output logic [31:0] dm_wdata
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BREQ = 6'h04;
  localparam logic [5:0] OP_JUMP = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc;

  logic [31:0] instr;
  logic [5:0]  opc, fn;
  logic [4:0]  ra, rb, rdst;
  logic [31:0] imm;
  logic        is_reg, is_load, is_store, is_beq, is_jump;
  logic [31:0] a_val, b_val, alu_b, alu_y, mem_q;
  logic [31:0] pc_next4, br_target, jmp_target, pc_next;
  logic        reg_we;
  logic [4:0]  dest;

  wire unused_ld = ^{ld_addr[31:IAW+2], ld_addr[1:0]};

  assign instr = imem[pc[IAW+1:2]];
  assign opc   = instr[31:26];
  assign ra    = instr[25:21];
  assign rb    = instr[20:16];
  assign rdst  = instr[15:11];
  assign fn    = instr[5:0];
  assign imm   = {{16{instr[15]}}, instr[15:0]};

  assign is_reg   = (opc == OP_REG) &&
                    (fn == FN_ADD || fn == FN_SUB || fn == FN_AND ||
                     fn == FN_OR  || fn == FN_SLT);
  assign is_load  = (opc == OP_LOAD);
  assign is_store = (opc == OP_STOR);
  assign is_beq   = (opc == OP_BREQ);
  assign is_jump  = (opc == OP_JUMP);

  assign a_val = (ra == 5'd0) ? 32'd0 : rf[ra];
  assign b_val = (rb == 5'd0) ? 32'd0 : rf[rb];
  assign alu_b = is_reg ? b_val : imm;

  always_comb begin
    alu_y = a_val + alu_b;
    if (is_reg) begin
      case (fn)
        FN_SUB:  alu_y = a_val - alu_b;
        FN_AND:  alu_y = a_val & alu_b;
        FN_OR:   alu_y = a_val | alu_b;
        FN_SLT:  alu_y = {31'd0, $signed(a_val) < $signed(alu_b)};
        default: alu_y = a_val + alu_b;
      endcase
    end
  end

  assign mem_q = dmem[alu_y[DAW+1:2]];

  assign pc_next4   = pc + 32'd4;
  assign br_target  = pc_next4 + {imm[29:0], 2'b00};
  assign jmp_target = {pc_next4[31:28], instr[25:0], 2'b00};

  always_comb begin
    pc_next = pc_next4;
    if (is_jump)                       pc_next = jmp_target;
    else if (is_beq && a_val == b_val) pc_next = br_target;
  end

  assign dest   = is_reg ? rdst : rb;
  assign reg_we = (is_reg || is_load) && !rst && (dest != 5'd0);

  assign pc_o     = pc;
  assign wb_en    = reg_we;
  assign wb_reg   = dest;
  assign wb_data  = is_load ? mem_q : alu_y;
  assign dm_we    = is_store && !rst;
  assign dm_addr  = alu_y;
  assign dm_wdata = b_val;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (reg_we) rf[dest] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel)  dmem[ld_addr[DAW+1:2]] <= ld_data;
    else if (dm_we)       dmem[alu_y[DAW+1:2]]   <= b_val;
    if (ld_en && !ld_sel) imem[ld_addr[IAW+1:2]] <= ld_data;
  end

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_o == 32'd0);

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (!is_beq && !is_jump) |=> pc_o == $past(pc_o) + 32'd4);

  a_r5_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_reg != 5'd0);

  a_r7_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !wb_en);

  a_r8_beq_not_taken: assert property (@(posedge clk) disable iff (rst)
    (is_beq && a_val != b_val) |=> pc_o == $past(pc_o) + 32'd4);

  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> pc_o[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

// File: tb/sc_cpu_tb.sv
module sc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data, dm_addr, dm_wdata;
  logic        wb_en, dm_we;
  logic [4:0]  wb_reg;

  always #5 clk = ~clk;

  sc_cpu dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] prog [512];
  logic [31:0] dinit [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [64];
  logic [31:0] m_pc;
  int p = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (pc %h)", tag, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] enc_r(int f, int s, int t, int d);
    logic [5:0] fc [5];
    fc[0] = 6'h20; fc[1] = 6'h22; fc[2] = 6'h24; fc[3] = 6'h25; fc[4] = 6'h2A;
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fc[f]};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int off);
    return {op, 5'(s), 5'(t), 16'(off)};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[p] = w;
    p++;
  endtask

  task automatic step();
    logic [31:0] ins, a, b, imm, y, npc, p4;
    logic [5:0]  op, fn;
    logic [4:0]  s, t, d;
    logic        rw, sw;
    logic [4:0]  dst;
    logic [31:0] wv;
    string       tag;
    ins = prog[m_pc[10:2]];
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; fn = ins[5:0];
    a = m_rf[s]; b = m_rf[t];
    imm = {{16{ins[15]}}, ins[15:0]};
    p4 = m_pc + 32'd4;
    npc = p4; rw = 0; sw = 0; dst = 5'd0; wv = 32'd0; tag = "R2";
    y = a + imm;
    if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
      rw = 1; dst = d; tag = "R3";
      case (fn)
        6'h20: wv = a + b;
        6'h22: wv = a - b;
        6'h24: wv = a & b;
        6'h25: wv = a | b;
        default: begin wv = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
      endcase
      if (s == d || t == d) tag = "R11";
    end else if (op == 6'h23) begin
      rw = 1; dst = t; wv = m_dm[y[7:2]]; tag = "R6";
    end else if (op == 6'h2B) begin
      sw = 1; tag = "R7";
    end else if (op == 6'h04) begin
      tag = "R8";
      if (a == b) npc = p4 + {imm[29:0], 2'b00};
    end else if (op == 6'h02) begin
      tag = "R9";
      npc = {p4[31:28], ins[25:0], 2'b00};
    end
    if (rw && dst == 5'd0) begin rw = 0; tag = "R5"; end
    chk(pc_o, m_pc, tag);
    chk({31'd0, wb_en}, {31'd0, rw}, tag);
    if (rw) begin
      chk({27'd0, wb_reg}, {27'd0, dst}, tag);
      chk(wb_data, wv, tag);
    end
    chk({31'd0, dm_we}, {31'd0, sw}, tag);
    if (sw) begin
      chk(dm_addr, y, tag);
      chk(dm_wdata, b, tag);
    end
    if (rw) m_rf[dst] = wv;
    if (sw) m_dm[y[7:2]] = b;
    m_pc = npc;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int halt_at, stay, loop_at;
    for (int i = 0; i < 512; i++) prog[i] = 32'hFC00_0000;
    for (int i = 0; i < 64; i++) dinit[i] = 32'h0101_0101 * i;
    dinit[0] = 32'h0000_0000; dinit[1] = 32'h0000_0001; dinit[2] = 32'hFFFF_FFFF;
    dinit[3] = 32'h7FFF_FFFF; dinit[4] = 32'h8000_0000; dinit[5] = 32'h0000_0005;
    dinit[6] = 32'h1234_5678; dinit[7] = 32'hFFFF_FFFB;
    dinit[8] = 32'd64;        dinit[9] = 32'd3;

    for (int i = 1; i <= 8; i++) emit(enc_i(6'h23, 0, i, (i - 1) * 4));
    for (int a = 1; a <= 8; a++)
      for (int b = 1; b <= 8; b++)
        for (int f = 0; f < 5; f++)
          emit(enc_r(f, a, b, 10 + ((a * 8 + b + f) % 20)));
    emit(enc_r(0, 1, 6, 0));          // R5: write to r0 is dropped
    emit(enc_r(0, 0, 3, 9));          // R5: r0 reads zero
    emit(enc_r(0, 6, 6, 6));          // R11: reads old r6
    emit(enc_r(1, 6, 6, 6));          // R11
    emit(enc_i(6'h23, 0, 21, 32));    // r21 = 64
    emit(enc_i(6'h2B, 0, 7, 40));     // R7 positive offset
    emit(enc_i(6'h23, 0, 20, 40));
    emit(enc_i(6'h2B, 21, 3, -4));    // R7 negative offset
    emit(enc_i(6'h23, 21, 22, -4));   // R6 negative offset
    emit(enc_i(6'h2B, 21, 5, 0));
    emit(enc_i(6'h23, 21, 23, 0));
    emit(enc_i(6'h04, 1, 2, 1));      // R8 not taken
    emit(enc_r(0, 4, 4, 23));
    emit(enc_i(6'h04, 3, 3, 1));      // R8 taken forward
    emit(enc_r(0, 0, 0, 23));         // skipped
    emit(enc_r(0, 23, 0, 25));
    emit(32'hFC00_0000);              // R2 unknown opcode
    emit(32'h0023_2000);              // R2 unknown function code
    emit(32'h2021_0005);              // R2 unsupported immediate op
    emit(enc_i(6'h23, 0, 24, 36));    // r24 = 3
    loop_at = p;
    emit(enc_r(1, 24, 2, 24));
    emit(enc_r(4, 0, 24, 26));
    emit(enc_i(6'h04, 26, 2, loop_at - (p + 1)));  // R8 backward
    halt_at = p + 2;
    emit({6'h02, 26'(halt_at)});      // R9 jump forward
    emit(enc_r(0, 1, 1, 27));         // skipped
    emit({6'h02, 26'(halt_at)});      // R9 jump to self

    @(negedge clk);
    ld_en = 1'b1;
    ld_sel = 1'b0;
    for (int i = 0; i < 512; i++) begin
      ld_addr = 32'(i * 4); ld_data = prog[i]; @(negedge clk);
    end
    ld_sel = 1'b1;
    for (int i = 0; i < 64; i++) begin
      ld_addr = 32'(i * 4); ld_data = dinit[i]; @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    chk(pc_o, 32'd0, "R1");
    chk({31'd0, wb_en}, 32'd0, "R1");
    chk({31'd0, dm_we}, 32'd0, "R1");

    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    for (int i = 0; i < 64; i++) m_dm[i] = dinit[i];
    m_pc = 32'd0;
    rst = 1'b0;
    stay = 0;
    for (int cyc = 0; cyc < 3000 && stay < 3; cyc++) begin
      #1;
      step();
      if (m_pc == 32'(halt_at * 4)) stay++;
      @(negedge clk);
    end
    chk(32'(stay), 32'd3, "R8");      // R8/R9: loop exited and halt reached

    rst = 1'b1;
    @(negedge clk);
    chk(pc_o, 32'd0, "R1");
    chk({31'd0, wb_en}, 32'd0, "R1");
    // R10: reload a data word through the load port and read it back
    ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 32'd4; ld_data = 32'hCAFE_0001;
    @(negedge clk);
    ld_sel = 1'b0; ld_addr = 32'd0; ld_data = enc_i(6'h23, 0, 11, 4);
    @(negedge clk);
    ld_en = 1'b0;
    rst = 1'b0;
    #1;
    chk({31'd0, wb_en}, 32'd1, "R10");
    chk(wb_data, 32'hCAFE_0001, "R10");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule